// File: doc/BRIEF.md
# DMA Channel Request Front End

This block sits between the peripherals that ask for DMA service and the transfer engine of a multi-channel DMA controller. Each of its 21 channels has two hardware request inputs, one asking for a burst and one asking for a single transfer. On top of these there is a software request, raised by a register write. For every channel the block produces a request strobe, and a flag that says whether the request is a burst of 2^R transfers or a single transfer. The value R comes from the engine's own channel setup.

A small word-addressed register bus drives the block. Two of its words set and clear a burst-only mask. While a channel's mask is set, the channel ignores its single-request input. Only channels 4 and 5 carry this mask. A third word raises software requests, and a fourth word reads back the mask.

Each channel runs two small state machines. The pending machine has the states CH_IDLE and CH_SWPEND. It moves from CH_IDLE to CH_SWPEND on a software pulse for that channel. It moves from CH_SWPEND back to CH_IDLE when the engine acknowledges the channel in a cycle that brings no new software pulse. The mask machine has the states MK_OPEN and MK_BURST_ONLY. It moves from MK_OPEN to MK_BURST_ONLY on a set pulse that comes without a clear pulse. It moves from MK_BURST_ONLY to MK_OPEN on a clear pulse. On channels that have no mask, both pulses are forced low, so the mask machine stays in MK_OPEN.

Top module: `dmarq_front`

## Requirements
- R1: After reset, `req_o` and `req_burst_o` are all zero, and reading the mask status word (address 3) returns 0.
- R2: A write to address 0 with bit c = 1 makes channel c pending from the next clock edge on. A pending channel shows `req_o[c]` = 1 and `req_burst_o[c]` = 1. Bits written as 0 change nothing.
- R3: A pending channel stays pending until a cycle in which `eng_ack_i[c]` = 1 and no new software write to bit c arrives. `eng_ack_i` has no effect on a channel that is not pending.
- R4: A write to address 1 with bit c = 1 sets the mask bit of channel c. Bits written as 0 leave the mask unchanged.
- R5: A write to address 2 with bit c = 1 clears the mask bit of channel c. This is the only way to clear it. Bits written as 0 change nothing. A clear wins over a set aimed at the same bit in the same cycle.
- R6: The mask exists only on channels 4 and 5, at bits 4 and 5 of the status word. On every other channel, mask writes do nothing and the bit reads 0.
- R7: While channel c is masked, `hw_single_i[c]` is ignored. Only `hw_burst_i[c]`, or a pending software request, asserts `req_o[c]`, and it always asserts it together with `req_burst_o[c]`.
- R8: On an unmasked channel, `hw_single_i[c]` alone gives `req_o[c]` = 1 with `req_burst_o[c]` = 0, and `hw_burst_i[c]` gives both outputs 1. The hardware inputs reach the outputs in the same cycle.
- R9: When `hw_burst_i[c]` and `hw_single_i[c]` are both high on an unmasked channel, the burst wins and `req_burst_o[c]` = 1.
- R10: Bits 31:21 of every word read as zero and ignore writes. Addresses 0, 1 and 2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | 2 | Word index: 0 software request, 1 mask set, 2 mask clear, 3 mask status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr`, combinational |
| hw_burst_i | input | 21 | Per-channel hardware burst request |
| hw_single_i | input | 21 | Per-channel hardware single request |
| eng_ack_i | input | 21 | Per-channel acknowledge from the transfer engine |
| req_o | output | 21 | Per-channel request strobe |
| req_burst_o | output | 21 | Per-channel burst flag, meaningful while `req_o` is high |

## Verification
Suppose a mask machine lands in the wrong state. Then the status word shows it on the very next read, and a single request on channel 4 or 5 shows it in the same cycle, either as a missing strobe or as a wrong burst flag. Suppose a pending machine lands in the wrong state. Then `req_o` shows it on the next cycle: a software request that never appears, a request that survives its acknowledge, or a request lost when an acknowledge and a new write arrive together. The bench therefore brings each machine into each of its states through the bus, and reads the result back on the following cycle.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    localparam int NCH      = 21;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam logic [NCH-1:0] MASKABLE_DEF = 21'h000030;

    typedef enum logic [ADDR_W-1:0] {
        RG_SWREQ = 2'd0,
        RG_MSET  = 2'd1,
        RG_MCLR  = 2'd2,
        RG_MSTAT = 2'd3
    } reg_idx_e;

    typedef enum logic {
        CH_IDLE   = 1'b0,
        CH_SWPEND = 1'b1
    } pend_st_e;

    typedef enum logic {
        MK_OPEN       = 1'b0,
        MK_BURST_ONLY = 1'b1
    } mask_st_e;

endpackage

// File: rtl/dmarq_decode.sv
module dmarq_decode
    import dmarq_pkg::*;
#(
    parameter int N  = NCH,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  wbits,
    input  logic [N-1:0]  mask_vec,
    output logic [N-1:0]  sw_pulse,
    output logic [N-1:0]  mset_pulse,
    output logic [N-1:0]  mclr_pulse,
    output logic [DW-1:0] rdata
);

    localparam int PAD = DW - N;

    reg_idx_e idx;
    assign idx = reg_idx_e'(bus_addr);

    always_comb begin
        sw_pulse   = '0;
        mset_pulse = '0;
        mclr_pulse = '0;
        if (bus_wr) begin
            unique case (idx)
                RG_SWREQ: sw_pulse   = wbits;
                RG_MSET:  mset_pulse = wbits;
                RG_MCLR:  mclr_pulse = wbits;
                RG_MSTAT: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            RG_MSTAT: rdata = {{PAD{1'b0}}, mask_vec};
            RG_SWREQ,
            RG_MSET,
            RG_MCLR:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmarq_chan.sv
module dmarq_chan
    import dmarq_pkg::*;
#(
    parameter bit HAS_MASK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_pulse,
    input  logic mset,
    input  logic mclr,
    input  logic hw_burst,
    input  logic hw_single,
    input  logic ack,
    output logic req,
    output logic burst,
    output logic mask_q,
    output logic pend_q
);

    pend_st_e pst, pst_nx;
    mask_st_e mst, mst_nx;
    logic     set_ok, clr_ok;

    assign set_ok = mset & HAS_MASK;
    assign clr_ok = mclr & HAS_MASK;

    always_comb begin
        pst_nx = pst;
        unique case (pst)
            CH_IDLE:   if (sw_pulse)         pst_nx = CH_SWPEND;
            CH_SWPEND: if (ack && !sw_pulse) pst_nx = CH_IDLE;
        endcase
    end

    always_comb begin
        mst_nx = mst;
        unique case (mst)
            MK_OPEN:       if (set_ok && !clr_ok) mst_nx = MK_BURST_ONLY;
            MK_BURST_ONLY: if (clr_ok)            mst_nx = MK_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pst <= CH_IDLE;
            mst <= MK_OPEN;
        end else begin
            pst <= pst_nx;
            mst <= mst_nx;
        end
    end

    always_comb begin
        pend_q = (pst == CH_SWPEND);
        mask_q = (mst == MK_BURST_ONLY);
        burst  = pend_q | hw_burst;
        req    = burst | (hw_single & ~mask_q);
    end

endmodule

// File: rtl/dmarq_front.sv
module dmarq_front
    import dmarq_pkg::*;
#(
    parameter int               N        = NCH,
    parameter int               DW       = DATA_W,
    parameter int               AW       = ADDR_W,
    parameter logic [N-1:0]     MASKABLE = MASKABLE_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  hw_burst_i,
    input  logic [N-1:0]  hw_single_i,
    input  logic [N-1:0]  eng_ack_i,
    output logic [N-1:0]  req_o,
    output logic [N-1:0]  req_burst_o
);

    logic [N-1:0] sw_pulse, mset_pulse, mclr_pulse;
    logic [N-1:0] mask_vec, pend_vec;
    logic         unused_rsvd;

    assign unused_rsvd = ^bus_wdata[DW-1:N];

    dmarq_decode #(.N(N), .DW(DW), .AW(AW)) u_dec (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .wbits      (bus_wdata[N-1:0]),
        .mask_vec   (mask_vec),
        .sw_pulse   (sw_pulse),
        .mset_pulse (mset_pulse),
        .mclr_pulse (mclr_pulse),
        .rdata      (bus_rdata)
    );

    for (genvar c = 0; c < N; c++) begin : g_ch
        dmarq_chan #(.HAS_MASK(MASKABLE[c])) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .sw_pulse  (sw_pulse[c]),
            .mset      (mset_pulse[c]),
            .mclr      (mclr_pulse[c]),
            .hw_burst  (hw_burst_i[c]),
            .hw_single (hw_single_i[c]),
            .ack       (eng_ack_i[c]),
            .req       (req_o[c]),
            .burst     (req_burst_o[c]),
            .mask_q    (mask_vec[c]),
            .pend_q    (pend_vec[c])
        );
    end

endmodule

// File: rtl/dmarq_front_chk.sv
module dmarq_front_chk #(
    parameter int           N        = 21,
    parameter int           DW       = 32,
    parameter int           AW       = 2,
    parameter logic [N-1:0] MASKABLE = 21'h000030
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [N-1:0]  hw_burst_i,
    input logic [N-1:0]  hw_single_i,
    input logic [N-1:0]  eng_ack_i,
    input logic [N-1:0]  req_o,
    input logic [N-1:0]  req_burst_o,
    input logic [N-1:0]  mask_vec,
    input logic [N-1:0]  pend_vec
);

    logic [N-1:0] sw_now;
    assign sw_now = (bus_wr && bus_addr == '0) ? bus_wdata[N-1:0] : '0;

    a_r2_sw_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_now != '0) |=> ((req_o & req_burst_o & $past(sw_now)) == $past(sw_now)));

    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_ack_i & ~sw_now) != '0) |=> ((pend_vec & $past(eng_ack_i & ~sw_now)) == '0));

    a_r6_unmasked_stay_open: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_vec & ~MASKABLE) == '0));

    a_r7_masked_single_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_o & mask_vec & ~hw_burst_i & ~pend_vec) == '0));

    a_r8_flag_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_burst_o & ~req_o) == '0));

    a_r9_burst_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_burst_o & hw_burst_i) == hw_burst_i));

    a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[DW-1:N] == '0));

endmodule

bind dmarq_front dmarq_front_chk #(.N(N), .DW(DW), .AW(AW), .MASKABLE(MASKABLE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .hw_burst_i  (hw_burst_i),
    .hw_single_i (hw_single_i),
    .eng_ack_i   (eng_ack_i),
    .req_o       (req_o),
    .req_burst_o (req_burst_o),
    .mask_vec    (mask_vec),
    .pend_vec    (pend_vec)
);

// File: tb/dmarq_front_test.sv
module dmarq_front_test;

    localparam int N = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  hw_burst_i = '0;
    logic [N-1:0]  hw_single_i = '0;
    logic [N-1:0]  eng_ack_i = '0;
    logic [N-1:0]  req_o, req_burst_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dmarq_front uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_burst_i(hw_burst_i),
        .hw_single_i(hw_single_i), .eng_ack_i(eng_ack_i), .req_o(req_o),
        .req_burst_o(req_burst_o)
    );

    // {hw_burst, hw_single, expected req, expected burst flag}; mask = channel 4 only
    localparam logic [83:0] TBL [9] = '{
        {21'h000000, 21'h000000, 21'h000000, 21'h000000},
        {21'h000000, 21'h000001, 21'h000001, 21'h000000},
        {21'h000002, 21'h000000, 21'h000002, 21'h000002},
        {21'h000000, 21'h000010, 21'h000000, 21'h000000},
        {21'h000010, 21'h000000, 21'h000010, 21'h000010},
        {21'h000020, 21'h000020, 21'h000020, 21'h000020},
        {21'h000000, 21'h1FFFFF, 21'h1FFFEF, 21'h000000},
        {21'h100000, 21'h0FFFFF, 21'h1FFFEF, 21'h100000},
        {21'h000010, 21'h000010, 21'h000010, 21'h000010}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 req", {11'd0, req_o}, 32'd0);
        chk("R1 burst", {11'd0, req_burst_o}, 32'd0);
        rd_chk("R1 mask status", 2'd3, 32'd0);

        // mask register behaviour
        wr(2'd1, 32'hFFFF_FFFF);
        rd_chk("R6 R10 set all", 2'd3, 32'h0000_0030);
        wr(2'd2, 32'h0000_0000);
        rd_chk("R5 clear zero", 2'd3, 32'h0000_0030);
        wr(2'd2, 32'h0000_0010);
        rd_chk("R5 clear ch4", 2'd3, 32'h0000_0020);
        wr(2'd1, 32'h0000_0000);
        rd_chk("R4 set zero", 2'd3, 32'h0000_0020);
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk("R5 clear all", 2'd3, 32'h0000_0000);
        wr(2'd1, 32'h0000_0010);
        rd_chk("R4 set ch4", 2'd3, 32'h0000_0010);
        rd_chk("R10 read word0", 2'd0, 32'd0);
        rd_chk("R10 read word1", 2'd1, 32'd0);
        rd_chk("R10 read word2", 2'd2, 32'd0);

        // hardware request combining
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            hw_burst_i  = TBL[i][83:63];
            hw_single_i = TBL[i][62:42];
            #1;
            chk("R7 R8 R9 req", {11'd0, req_o}, {11'd0, TBL[i][41:21]});
            chk("R7 R8 R9 flag", {11'd0, req_burst_o}, {11'd0, TBL[i][20:0]});
        end
        @(negedge clk);
        hw_burst_i = '0; hw_single_i = '0;

        // software requests
        @(negedge clk);
        eng_ack_i = 21'h000001;
        @(negedge clk);
        eng_ack_i = '0;
        #1;
        chk("R3 ack idle", {11'd0, req_o}, 32'd0);
        wr(2'd0, 32'h0000_0005);
        #1;
        chk("R2 sw req", {11'd0, req_o}, 32'h5);
        chk("R2 sw flag", {11'd0, req_burst_o}, 32'h5);
        wr(2'd0, 32'h0000_0000);
        #1;
        chk("R2 write zero", {11'd0, req_o}, 32'h5);
        @(negedge clk);
        eng_ack_i = 21'h000001;
        @(negedge clk);
        eng_ack_i = '0;
        #1;
        chk("R3 ack clears", {11'd0, req_o}, 32'h4);
        @(negedge clk);
        eng_ack_i = 21'h000004;
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h4;
        @(negedge clk);
        eng_ack_i = '0; bus_wr = 1'b0; bus_wdata = '0;
        #1;
        chk("R3 ack with new write", {11'd0, req_o}, 32'h4);
        @(negedge clk);
        eng_ack_i = 21'h000004;
        @(negedge clk);
        eng_ack_i = '0;
        #1;
        chk("R3 ack second", {11'd0, req_o}, 32'h0);
        wr(2'd0, 32'hFFE0_0000);
        #1;
        chk("R10 sw reserved", {11'd0, req_o}, 32'h0);
        wr(2'd0, 32'h0000_0010);
        #1;
        chk("R7 sw on masked ch", {11'd0, req_burst_o}, 32'h10);
        finish_run();
    end

endmodule